// File: doc/BRIEF.md
# Event Routing Channel

This block is a single channel of a peripheral event router. Software sets it up with one 32-bit write to a configuration register. That value picks one generator line out of a bank of up to 256 inputs. It also chooses how the picked signal reaches the channel output. There are three routings:

- **Synchronous:** the line is sampled directly on the channel clock.
- **Resynchronized:** the line first passes through a two-flop synchronizer.
- **Asynchronous:** the line passes straight to the output.

On the two clocked routings, an edge qualifier turns the level or pulse from the generator into a one-cycle event pulse. It can fire on rising edges, falling edges, both, or never.

The channel also drives a clock-request output. This output is either held high while the channel is configured, or raised only while an event is moving through the channel. A standby input turns the channel off unless the configuration asks it to keep running in standby.

A channel index parameter fixes, at elaboration time, whether the clocked routings exist. Channels numbered 12 and above are wired for the asynchronous routing only. Any request for a clocked routing on such a channel is stored as asynchronous.

Top module: `evt_route_channel`

## Requirements
- R1: After reset the configuration reads back 0x00008000: on-demand flag (bit 15) is 1 and every other bit is 0.
- R2: A write stores on-demand at bit 15, run-in-standby at bit 14, edge mode at bits 11:10, routing at bits 9:8 and generator select at bits 7:0; every other bit reads back as 0.
- R3: Routing code 2 is asynchronous, and a written routing code 3 is stored and read back as 2.
- R4: On a channel whose index is 12 or above, written routing codes 0 (synchronous) and 1 (resynchronized) are stored and read back as 2, and the channel behaves as asynchronous.
- R5: Generator select 0 connects no generator: once select 0 has been held for three cycles, the event output stays low whatever the generator inputs do.
- R6: On the asynchronous routing, the event output equals the selected generator input in the same cycle, with no edge qualification, whatever the edge mode holds.
- R7: On the synchronous routing (code 0) with rising-edge mode, a generator rise sampled at clock edge k makes the event output high from edge k to edge k+1, and low after that.
- R8: On the resynchronized routing (code 1), the same rise gives the pulse one cycle later, from edge k+1 to edge k+2.
- R9: Edge mode 0 gives no event, 1 gives rising edges only, 2 gives falling edges only and 3 gives both, each as a one-cycle pulse; a rise followed at once by a fall in mode 3 gives two pulses back to back.
- R10: While standby is high and run-in-standby is 0, the event output and the clock request are both low. With run-in-standby at 1, the channel behaves as if standby were low.
- R11: With on-demand at 0, the clock request is high whenever the channel is active and the generator select is non-zero.
- R12: With on-demand at 1, the clock request is high while an edge is in flight. On the clocked routings, that means the selected input differs from any pipeline stage that the routing uses. On the asynchronous routing, the request follows the selected input level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Channel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_rdata | output | 32 | Stored configuration |
| gen_in | input | NUM_GEN | Event generator lines |
| standby | input | 1 | Standby sleep indication |
| chan_evt | output | 1 | Channel event output |
| gclk_req | output | 1 | Generic clock request |

## Verification
Any error in the pipeline stages shows at chan_evt within three cycles of a generator transition. The error is a pulse that is missing, arrives late, is doubled or has the wrong polarity. A wrong stored field shows in two ways: at once on cfg_rdata after a write, and as a wrong routing or edge choice on the next generator edge. The clock-request logic uses the same stages, so a stale stage also shows as gclk_req that stays high, or drops, one cycle off from the bench's expected value. Running a channel below the index limit and one above it side by side exposes any routing-capability decode that ignores the index.

// File: rtl/evt_route_pkg.sv
package evt_route_pkg;

  localparam int CFG_W    = 32;
  localparam int SEL_W    = 8;
  localparam int BIT_ONDM = 15;
  localparam int BIT_STBY = 14;
  localparam int EDGE_LSB = 10;
  localparam int PATH_LSB = 8;
  localparam int SEL_LSB  = 0;

  typedef enum logic [1:0] {
    PATH_SYNC   = 2'd0,
    PATH_RESYNC = 2'd1,
    PATH_ASYNC  = 2'd2,
    PATH_RSVD   = 2'd3
  } path_e;

  typedef enum logic [1:0] {
    EDGE_NONE = 2'd0,
    EDGE_RISE = 2'd1,
    EDGE_FALL = 2'd2,
    EDGE_BOTH = 2'd3
  } edge_e;

  typedef struct packed {
    logic             on_demand;
    logic             run_stby;
    edge_e            edge_mode;
    path_e            path;
    logic [SEL_W-1:0] sel;
  } chan_cfg_t;

  function automatic path_e legal_path(input logic [1:0] req, input bit sync_cap);
    if (req == PATH_RSVD)                  return PATH_ASYNC;
    if (!sync_cap && (req != PATH_ASYNC))  return PATH_ASYNC;
    return path_e'(req);
  endfunction

endpackage

// File: rtl/evt_cfg_reg.sv
module evt_cfg_reg
  import evt_route_pkg::*;
#(
  parameter bit SYNC_CAP = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [CFG_W-1:0] wdata,
  output chan_cfg_t        cfg,
  output logic [CFG_W-1:0] rdata
);

  chan_cfg_t cfg_q, cfg_d;

  always_comb begin
    cfg_d = cfg_q;
    if (wr_en) begin
      cfg_d.on_demand = wdata[BIT_ONDM];
      cfg_d.run_stby  = wdata[BIT_STBY];
      cfg_d.edge_mode = edge_e'(wdata[EDGE_LSB +: 2]);
      cfg_d.path      = legal_path(wdata[PATH_LSB +: 2], SYNC_CAP);
      cfg_d.sel       = wdata[SEL_LSB +: SEL_W];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q.on_demand <= 1'b1;
      cfg_q.run_stby  <= 1'b0;
      cfg_q.edge_mode <= EDGE_NONE;
      cfg_q.path      <= PATH_SYNC;
      cfg_q.sel       <= '0;
    end else if (wr_en) begin
      cfg_q <= cfg_d;
    end
  end

  assign cfg = cfg_q;

  always_comb begin
    rdata                     = '0;
    rdata[BIT_ONDM]           = cfg_q.on_demand;
    rdata[BIT_STBY]           = cfg_q.run_stby;
    rdata[EDGE_LSB +: 2]      = cfg_q.edge_mode;
    rdata[PATH_LSB +: 2]      = cfg_q.path;
    rdata[SEL_LSB +: SEL_W]   = cfg_q.sel;
  end

  // R3: the reserved routing code never reaches the stored state
  assert_no_rsvd_path_R3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (cfg_q.path != PATH_RSVD));

  generate
    if (!SYNC_CAP) begin : g_async_only
      // R4: an async-only channel stores only the asynchronous routing after any write
      assert_async_only_R4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (cfg_q.path == PATH_ASYNC));
    end
  endgenerate

endmodule

// File: rtl/evt_gen_mux.sv
module evt_gen_mux
  import evt_route_pkg::*;
#(
  parameter int NUM_GEN = 256
) (
  input  logic [NUM_GEN-1:0] gen_in,
  input  logic [SEL_W-1:0]   sel,
  output logic               sig
);

  always_comb begin
    sig = 1'b0;
    for (int i = 1; i < NUM_GEN; i++) begin
      if (sel == SEL_W'(i)) sig = gen_in[i];
    end
  end

endmodule

// File: rtl/evt_edge_path.sv
module evt_edge_path
  import evt_route_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  sig_in,
  input  path_e path,
  input  edge_e edge_mode,
  input  logic  active,
  output logic  evt,
  output logic  busy
);

  logic stg_a_q, stg_b_q, stg_c_q;
  logic stg_a_d, stg_b_d, stg_c_d;
  logic is_async, is_resync;
  logic cur, prv, rise, fall, hit;

  assign is_async  = (path == PATH_ASYNC);
  assign is_resync = (path == PATH_RESYNC);

  always_comb begin
    stg_a_d = sig_in;
    stg_b_d = stg_a_q;
    stg_c_d = stg_b_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg_a_q <= 1'b0;
      stg_b_q <= 1'b0;
      stg_c_q <= 1'b0;
    end else begin
      stg_a_q <= stg_a_d;
      stg_b_q <= stg_b_d;
      stg_c_q <= stg_c_d;
    end
  end

  always_comb begin
    cur  = is_resync ? stg_b_q : stg_a_q;
    prv  = is_resync ? stg_c_q : stg_b_q;
    rise = cur & ~prv;
    fall = ~cur & prv;
    unique case (edge_mode)
      EDGE_RISE: hit = rise;
      EDGE_FALL: hit = fall;
      EDGE_BOTH: hit = rise | fall;
      default:   hit = 1'b0;
    endcase
  end

  always_comb begin
    evt  = active & (is_async ? sig_in : hit);
    busy = is_async ? sig_in
                    : ((sig_in ^ stg_a_q) | (stg_a_q ^ stg_b_q) | (is_resync & (stg_b_q ^ stg_c_q)));
  end

  // R9: single-edge modes never give two pulses in a row while the setup holds
  assert_single_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (evt && !is_async && edge_mode != EDGE_BOTH)
      |=> (!evt || !$stable(path) || !$stable(edge_mode) || !$stable(sig_in) || is_async));

  // R7: a synchronous rising pulse follows a high sample preceded by a low one
  assert_sync_rise_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (evt && path == PATH_SYNC && edge_mode == EDGE_RISE && $stable(path))
      |-> ($past(sig_in) && !$past(stg_a_q)));

endmodule

// File: rtl/evt_clk_req.sv
module evt_clk_req (
  input  logic clk,
  input  logic rst_n,
  input  logic active,
  input  logic on_demand,
  input  logic configured,
  input  logic busy,
  output logic req
);

  always_comb begin
    if (!active)       req = 1'b0;
    else if (on_demand) req = busy;
    else               req = configured;
  end

  // R12: in on-demand mode an idle channel drops its request
  assert_ondemand_idle_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (on_demand && !busy) |-> !req);

endmodule

// File: rtl/evt_route_channel.sv
module evt_route_channel
  import evt_route_pkg::*;
#(
  parameter int CH_INDEX      = 0,
  parameter int NUM_GEN       = 256,
  parameter int SYNC_CH_LIMIT = 12
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_wr,
  input  logic [31:0]        cfg_wdata,
  output logic [31:0]        cfg_rdata,
  input  logic [NUM_GEN-1:0] gen_in,
  input  logic               standby,
  output logic               chan_evt,
  output logic               gclk_req
);

  localparam bit SYNC_CAP = (CH_INDEX < SYNC_CH_LIMIT);

  chan_cfg_t cfg;
  logic      sel_sig;
  logic      active;
  logic      busy;

  evt_cfg_reg #(.SYNC_CAP(SYNC_CAP)) u_cfg (
    .clk   (clk),
    .rst_n (rst_n),
    .wr_en (cfg_wr),
    .wdata (cfg_wdata),
    .cfg   (cfg),
    .rdata (cfg_rdata)
  );

  evt_gen_mux #(.NUM_GEN(NUM_GEN)) u_mux (
    .gen_in (gen_in),
    .sel    (cfg.sel),
    .sig    (sel_sig)
  );

  assign active = ~(standby & ~cfg.run_stby);

  evt_edge_path u_path (
    .clk       (clk),
    .rst_n     (rst_n),
    .sig_in    (sel_sig),
    .path      (cfg.path),
    .edge_mode (cfg.edge_mode),
    .active    (active),
    .evt       (chan_evt),
    .busy      (busy)
  );

  evt_clk_req u_req (
    .clk        (clk),
    .rst_n      (rst_n),
    .active     (active),
    .on_demand  (cfg.on_demand),
    .configured (cfg.sel != '0),
    .busy       (busy),
    .req        (gclk_req)
  );

  // R10: standby without run-in-standby silences both outputs
  assert_standby_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (standby && !cfg_rdata[BIT_STBY]) |-> (!chan_evt && !gclk_req));

  // R5: a select held at zero keeps the event output low
  assert_sel_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg.sel == '0 && $past(cfg.sel) == '0 && $past(cfg.sel, 2) == '0 && $past(cfg.sel, 3) == '0)
      |-> !chan_evt);

  // R11: always-on mode keeps the request up for a configured, active channel
  assert_always_on_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_rdata[BIT_ONDM] && cfg_rdata[SEL_LSB +: SEL_W] != '0 && !standby) |-> gclk_req);

  // R6: asynchronous routing forwards the selected line unchanged
  assert_async_pass_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_rdata[PATH_LSB +: 2] == 2'd2 && !standby && cfg_rdata[SEL_LSB +: SEL_W] != '0)
      |-> (chan_evt == gen_in[cfg_rdata[SEL_LSB +: SEL_W]]));

endmodule

// File: tb/evt_route_channel_tb.sv
module evt_route_channel_tb;

  localparam int NG = 256;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [NG-1:0] gen_in;
  logic          standby;
  logic          wr [2];
  logic [31:0]   wd [2];
  logic [31:0]   rd [2];
  logic          evt [2];
  logic          req [2];

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;
  bit cmp_on = 1'b0;

  always #5 clk = ~clk;

  evt_route_channel #(.CH_INDEX(3), .NUM_GEN(NG)) u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_wr(wr[0]), .cfg_wdata(wd[0]), .cfg_rdata(rd[0]),
    .gen_in(gen_in), .standby(standby), .chan_evt(evt[0]), .gclk_req(req[0]));

  evt_route_channel #(.CH_INDEX(12), .NUM_GEN(NG)) u_dut_hi (
    .clk(clk), .rst_n(rst_n), .cfg_wr(wr[1]), .cfg_wdata(wd[1]), .cfg_rdata(rd[1]),
    .gen_in(gen_in), .standby(standby), .chan_evt(evt[1]), .gclk_req(req[1]));

  // requirement-level reference state
  logic       m_on   [2];
  logic       m_rs   [2];
  logic [1:0] m_edge [2];
  logic [1:0] m_path [2];
  logic [7:0] m_sel  [2];
  logic       ma [2];
  logic       mb [2];
  logic       mc [2];

  function automatic logic [1:0] norm_path(input logic [1:0] p, input int i);
    if (p == 2'd3) return 2'd2;
    if (i == 1 && p != 2'd2) return 2'd2;
    return p;
  endfunction

  function automatic logic genbit(input logic [7:0] s);
    return (s == 8'd0) ? 1'b0 : gen_in[s];
  endfunction

  always @(posedge clk or negedge rst_n) begin
    for (int i = 0; i < 2; i++) begin
      if (!rst_n) begin
        m_on[i] <= 1'b1; m_rs[i] <= 1'b0; m_edge[i] <= 2'd0; m_path[i] <= 2'd0; m_sel[i] <= 8'd0;
        ma[i] <= 1'b0; mb[i] <= 1'b0; mc[i] <= 1'b0;
      end else begin
        if (wr[i]) begin
          m_on[i]   <= wd[i][15];
          m_rs[i]   <= wd[i][14];
          m_edge[i] <= wd[i][11:10];
          m_path[i] <= norm_path(wd[i][9:8], i);
          m_sel[i]  <= wd[i][7:0];
        end
        ma[i] <= genbit(m_sel[i]);
        mb[i] <= ma[i];
        mc[i] <= mb[i];
      end
    end
  end

  function automatic logic exp_evt(input int i);
    logic act, s, cur, prv, e;
    act = !(standby && !m_rs[i]);
    s   = genbit(m_sel[i]);
    if (m_path[i] == 2'd2) e = s;
    else begin
      cur = (m_path[i] == 2'd1) ? mb[i] : ma[i];
      prv = (m_path[i] == 2'd1) ? mc[i] : mb[i];
      case (m_edge[i])
        2'd1:    e = cur & !prv;
        2'd2:    e = !cur & prv;
        2'd3:    e = cur ^ prv;
        default: e = 1'b0;
      endcase
    end
    return act & e;
  endfunction

  function automatic logic exp_req(input int i);
    logic s;
    if (standby && !m_rs[i]) return 1'b0;
    if (!m_on[i]) return (m_sel[i] != 8'd0);
    s = genbit(m_sel[i]);
    if (m_path[i] == 2'd2) return s;
    return (s != ma[i]) || (ma[i] != mb[i]) || ((m_path[i] == 2'd1) && (mb[i] != mc[i]));
  endfunction

  task automatic chk(input logic [31:0] got, input logic [31:0] exp, input string tag);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", tag, got, exp);
    end
  endtask

  task automatic cyc();
    @(negedge clk);
  endtask

  task automatic cfg_write(input int i, input logic [31:0] v);
    cyc(); wr[i] = 1'b1; wd[i] = v;
    cyc(); wr[i] = 1'b0;
  endtask

  task automatic settle(input int n);
    for (int k = 0; k < n; k++) cyc();
  endtask

  // continuous comparison during the random phase
  always @(negedge clk) begin
    if (cmp_on && rst_n) begin
      #2;
      for (int i = 0; i < 2; i++) begin
        chk({31'd0, evt[i]}, {31'd0, exp_evt(i)},
            (m_path[i] == 2'd0) ? "R7 sync event" : (m_path[i] == 2'd1) ? "R8 resync event" : "R6 async event");
        chk({31'd0, req[i]}, {31'd0, exp_req(i)}, "R12 clock request");
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 1'b0; gen_in = '0; standby = 1'b0;
    for (int i = 0; i < 2; i++) begin wr[i] = 1'b0; wd[i] = '0; end
    settle(3);
    rst_n = 1'b1;
    settle(2);
    #1;
    chk(rd[0], 32'h0000_8000, "R1 reset value ch3");
    chk(rd[1], 32'h0000_8000, "R1 reset value ch12");
    chk({31'd0, evt[0]}, 32'd0, "R1 reset event low");

    // R2 / R3 field layout and reserved code
    cfg_write(0, 32'hFFFF_FFFF); #1;
    chk(rd[0], 32'h0000_CEFF, "R3 reserved path stored async, R2 unused bits zero");
    cfg_write(0, 32'hA5A5_4505); #1;
    chk(rd[0], 32'h0000_4505, "R2 field positions");
    cfg_write(1, 32'h0000_4505); #1;
    chk(rd[1], 32'h0000_4605, "R4 resync on high channel becomes async");
    cfg_write(1, 32'h0000_0007); #1;
    chk(rd[1], 32'h0000_0207, "R4 sync on high channel becomes async");

    // R7 synchronous rising pulse
    gen_in = '0;
    cfg_write(0, 32'h0000_0405); settle(4);
    cyc(); gen_in[5] = 1'b1; #1; chk({31'd0, evt[0]}, 32'd0, "R7 no pulse before sampling");
    cyc(); #1; chk({31'd0, evt[0]}, 32'd1, "R7 pulse after sampling edge");
    cyc(); #1; chk({31'd0, evt[0]}, 32'd0, "R7 pulse is one cycle");

    // R8 resynchronized: one cycle later
    cfg_write(0, 32'h0000_0505); gen_in[5] = 1'b0; settle(4);
    cyc(); gen_in[5] = 1'b1;
    cyc(); #1; chk({31'd0, evt[0]}, 32'd0, "R8 no pulse after first edge");
    cyc(); #1; chk({31'd0, evt[0]}, 32'd1, "R8 pulse after second edge");
    cyc(); #1; chk({31'd0, evt[0]}, 32'd0, "R8 pulse is one cycle");

    // R9 falling-only, then both edges, then none
    cfg_write(0, 32'h0000_0805); settle(4);
    cyc(); gen_in[5] = 1'b0;
    cyc(); #1; chk({31'd0, evt[0]}, 32'd1, "R9 falling pulse");
    cyc(); gen_in[5] = 1'b1;
    cyc(); #1; chk({31'd0, evt[0]}, 32'd0, "R9 rise ignored in falling mode");
    cfg_write(0, 32'h0000_0C05); settle(4);
    cyc(); gen_in[5] = 1'b0;
    cyc(); gen_in[5] = 1'b1; #1; chk({31'd0, evt[0]}, 32'd1, "R9 both: fall pulse");
    cyc(); #1; chk({31'd0, evt[0]}, 32'd1, "R9 both: rise pulse back to back");
    cyc(); #1; chk({31'd0, evt[0]}, 32'd0, "R9 both: quiet afterwards");
    cfg_write(0, 32'h0000_0005); settle(3);
    cyc(); gen_in[5] = 1'b0;
    cyc(); #1; chk({31'd0, evt[0]}, 32'd0, "R9 mode none gives no event");

    // R5 select zero
    cfg_write(0, 32'h0000_0C00); gen_in = '1; settle(4);
    for (int k = 0; k < 4; k++) begin
      cyc(); gen_in = ~gen_in; #1;
      chk({31'd0, evt[0]}, 32'd0, "R5 select zero keeps output low");
    end

    // R6 async passthrough with edge mode ignored
    gen_in = '0;
    cfg_write(1, 32'h0000_0C07); #1;
    chk({31'd0, evt[1]}, 32'd0, "R6 async follows low");
    gen_in[7] = 1'b1; #1;
    chk({31'd0, evt[1]}, 32'd1, "R6 async follows high same cycle");

    // R10 / R11 standby and always-on request
    cfg_write(0, 32'h0000_0405); #1;
    chk({31'd0, req[0]}, 32'd1, "R11 always-on request");
    standby = 1'b1; #1;
    chk({31'd0, req[0]}, 32'd0, "R10 standby drops request");
    cyc(); gen_in[5] = 1'b1;
    cyc(); #1; chk({31'd0, evt[0]}, 32'd0, "R10 standby suppresses event");
    cfg_write(0, 32'h0000_4405); #1;
    chk({31'd0, req[0]}, 32'd1, "R10 run-in-standby keeps request");
    standby = 1'b0;

    // R12 on-demand request
    gen_in = '0;
    cfg_write(0, 32'h0000_8405); settle(4); #1;
    chk({31'd0, req[0]}, 32'd0, "R12 idle on-demand request low");
    cyc(); gen_in[5] = 1'b1; #1;
    chk({31'd0, req[0]}, 32'd1, "R12 request on input change");
    cyc(); #1; chk({31'd0, req[0]}, 32'd1, "R12 request while in flight");
    cyc(); #1; chk({31'd0, req[0]}, 32'd0, "R12 request drops when settled");

    // constrained random phase against the reference
    cmp_on = 1'b1;
    for (int t = 0; t < 3000; t++) begin
      cyc();
      if ($urandom_range(0, 2) == 0)
        for (int w = 0; w < NG / 32; w++) gen_in[w*32 +: 32] = $urandom;
      standby = ($urandom_range(0, 7) == 0);
      for (int i = 0; i < 2; i++) begin
        wr[i] = ($urandom_range(0, 15) == 0);
        wd[i] = $urandom;
        wd[i][7:0] = 8'($urandom_range(0, 15));
      end
    end
    cyc();
    wr[0] = 1'b0; wr[1] = 1'b0;
    cmp_on = 1'b0;
    settle(2);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule